// File: doc/BRIEF.md
# Transmit Low-Power-Idle Sequencer

This block decides when the transmit side of an Ethernet MAC may enter Low Power Idle (LPI), and when it may leave. It also records LPI transitions on both the transmit and receive paths. Software supplies an enable bit, an automatic-entry bit, a link-good bit and a packed timer word. The datapath supplies a transmit-idle level, a new-transmit-data request and the line-side receive-LPI level. A free-running microsecond tick paces both timers. A prescaler divides the tick down to milliseconds for the link-stable timer.

Entry is allowed only after the software link-good bit has been high for the programmed number of milliseconds. Dropping that bit at any point starts the wait again. When LPI ends, the transmitter stays blocked for the programmed number of microseconds, so the far end has time to wake. Four sticky flags record transmit entry, transmit exit, receive entry and receive exit. A status-read strobe clears all four flags. A maskable interrupt is raised while any flag is set.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `tx_lpi_req`, `tx_block`, `lpi_irq` and all four bits of `stat_flags` are 0.
- R2: `tmr_word` carries the wake time in microseconds in bits 15:0 and the link-stable time in milliseconds in bits 26:16.
- R3: With `phy_link_ok` held high from a given cycle, and entry otherwise allowed, `tx_lpi_req` rises after exactly MS_DIV*ls+1 clock edges when `us_tick` is high every cycle. A link-stable time of 0 gives entry on the first edge.
- R4: Taking `phy_link_ok` low for one cycle restarts the link-stable wait from zero.
- R5: With `lpi_en` low there is never entry. With `lpi_auto` high, entry also needs `tx_idle` high. With `lpi_auto` low, entry ignores `tx_idle`. Entry never happens while `tx_new_data` is high.
- R6: While in LPI, clearing `lpi_en` or raising `tx_new_data` drops `tx_lpi_req` on the next edge.
- R7: `tx_block` is high throughout LPI. After exit it stays high for exactly tw microsecond ticks, and for no cycle at all when tw is 0.
- R8: `stat_flags` bit 0 sets on transmit LPI entry, bit 1 on transmit exit, bit 2 on a rise of `rx_lpi` and bit 3 on a fall of `rx_lpi`. Each bit stays set until it is read.
- R9: A cycle with `stat_rd` high clears all flags at the next edge. An event in that same cycle leaves its own flag set.
- R10: `lpi_irq` is high exactly when some flag is set and `irq_mask` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lpi_en | input | 1 | LPI permitted |
| lpi_auto | input | 1 | Automatic entry when transmit is idle |
| phy_link_ok | input | 1 | Software link-good bit feeding the link-stable timer |
| irq_mask | input | 1 | Suppresses the interrupt when high |
| tmr_word | input | LS_W+TW_W (27) | {link-stable ms, wake us} |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| tx_idle | input | 1 | Transmit path has nothing to send |
| tx_new_data | input | 1 | New transmit data waiting |
| rx_lpi | input | 1 | Line side reports receive LPI |
| stat_rd | input | 1 | Status read strobe, clears flags |
| tx_lpi_req | output | 1 | Request LPI signalling on the transmit line |
| tx_block | output | 1 | Transmission must not start |
| lpi_irq | output | 1 | LPI event interrupt |
| stat_flags | output | 4 | Sticky flags {rx exit, rx entry, tx exit, tx entry} |

## Verification
The assertions check several rules on every cycle. A rise of `tx_lpi_req` must follow a cycle with the link bit, enable and no new data, plus idle when automatic entry is on. An exit cause must drop the request on the next edge. `tx_block` must cover every LPI cycle. Each transmit transition must leave its flag set. A masked interrupt must stay low.

Other properties can only be shown by the bench scenarios. These are the exact link-stable delay under a sweep of programmed times and the restart after a link drop. They also include the exact wake length under a sweep of wake times, and the clear-on-read behaviour when an event and a read share a cycle.

// File: rtl/eee_lpi_pkg.sv
// Package: shared state encoding and event-flag positions for the LPI sequencer.
// Assumes: flag positions are software visible and must stay fixed.
package eee_lpi_pkg;
    typedef enum logic [1:0] {
        TXS_ACTIVE = 2'd0,
        TXS_LPI    = 2'd1,
        TXS_WAKE   = 2'd2
    } tx_state_e;

    localparam int EVT_TX_ENTER = 0;
    localparam int EVT_TX_EXIT  = 1;
    localparam int EVT_RX_ENTER = 2;
    localparam int EVT_RX_EXIT  = 3;
    localparam int EVT_N        = 4;
endpackage

// File: rtl/eee_lpi_link_timer.sv
// Module: link-stable qualifier. Counts milliseconds (MS_DIV microsecond ticks
// each) while the link-good bit is high. Both counters reset whenever the bit
// is low. Assumes us_tick is a single-cycle pulse.
module eee_lpi_link_timer #(
    parameter int LS_W   = 11,
    parameter int MS_DIV = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            link_ok,
    input  logic            us_tick,
    input  logic [LS_W-1:0] ls_ms,
    output logic            link_ready
);
    localparam int PRE_W = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [LS_W-1:0]  ms_q;
    logic             ms_step;

    // Millisecond boundary: last tick of the prescaler period.
    assign ms_step = us_tick && (pre_q == PRE_LAST);

    // Prescaler: divides microsecond ticks into milliseconds.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_ok)
            pre_q <= '0;
        else if (ms_step)
            pre_q <= '0;
        else if (us_tick)
            pre_q <= pre_q + 1'b1;
    end

    // Millisecond counter: saturates at its maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_ok)
            ms_q <= '0;
        else if (ms_step && !(&ms_q))
            ms_q <= ms_q + 1'b1;
    end

    // Ready once the link has stayed good for the programmed time.
    assign link_ready = link_ok && (ms_q >= ls_ms);
endmodule

// File: rtl/eee_lpi_tx_fsm.sv
// Module: transmit LPI state machine (active -> lpi -> wake -> active).
// Emits one-cycle entry/exit event strobes that coincide with the state change.
// Assumes: the wake timer counts us_tick pulses.
module eee_lpi_tx_fsm
    import eee_lpi_pkg::*;
#(
    parameter int TW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            auto_entry,
    input  logic            tx_idle,
    input  logic            tx_new_data,
    input  logic            link_ready,
    input  logic            us_tick,
    input  logic [TW_W-1:0] tw_us,
    output logic            tx_lpi_req,
    output logic            tx_block,
    output logic            ev_enter,
    output logic            ev_exit
);
    tx_state_e       st_q, st_d;
    logic [TW_W-1:0] wcnt_q;
    logic            entry_ok;

    // Entry rule: enabled, link qualified, no pending data, idle if automatic.
    assign entry_ok = en && link_ready && !tx_new_data && (!auto_entry || tx_idle);

    // Next-state and event decode.
    always_comb begin
        st_d     = st_q;
        ev_enter = 1'b0;
        ev_exit  = 1'b0;
        case (st_q)
            TXS_ACTIVE: if (entry_ok) begin
                st_d     = TXS_LPI;
                ev_enter = 1'b1;
            end
            TXS_LPI: if (!en || tx_new_data) begin
                ev_exit = 1'b1;
                st_d    = (tw_us == '0) ? TXS_ACTIVE : TXS_WAKE;
            end
            TXS_WAKE: if (us_tick && wcnt_q == TW_W'(1))
                st_d = TXS_ACTIVE;
            default: st_d = TXS_ACTIVE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TXS_ACTIVE;
        else        st_q <= st_d;
    end

    // Wake countdown: loaded on exit, decremented per tick while waking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt_q <= '0;
        else if (ev_exit)
            wcnt_q <= tw_us;
        else if (st_q == TXS_WAKE && us_tick && wcnt_q != '0)
            wcnt_q <= wcnt_q - 1'b1;
    end

    assign tx_lpi_req = (st_q == TXS_LPI);
    assign tx_block   = (st_q != TXS_ACTIVE);
endmodule

// File: rtl/eee_lpi_evt_flags.sv
// Module: sticky event flags with clear-on-read and a maskable interrupt.
// Detects receive LPI edges itself. An event in the read cycle survives the clear.
module eee_lpi_evt_flags
    import eee_lpi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_enter,
    input  logic             tx_exit,
    input  logic             rx_lpi,
    input  logic             rd_clr,
    input  logic             irq_mask,
    output logic [EVT_N-1:0] flags,
    output logic             irq
);
    logic             rx_q;
    logic [EVT_N-1:0] evt;
    logic [EVT_N-1:0] flags_q;

    // Receive level history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b0;
        else        rx_q <= rx_lpi;
    end

    // Gather this cycle's events into their flag positions.
    always_comb begin
        evt               = '0;
        evt[EVT_TX_ENTER] = tx_enter;
        evt[EVT_TX_EXIT]  = tx_exit;
        evt[EVT_RX_ENTER] = rx_lpi && !rx_q;
        evt[EVT_RX_EXIT]  = !rx_lpi && rx_q;
    end

    // Sticky flags: a read clears them, new events set them.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (rd_clr ? '0 : flags_q) | evt;
    end

    assign flags = flags_q;
    assign irq   = (|flags_q) && !irq_mask;
endmodule

// File: rtl/eee_lpi_ctrl.sv
// Module: top of the transmit low-power-idle sequencer. Unpacks the timer word
// ({link-stable ms, wake us}) and wires the link timer, the transmit state machine
// and the event flags. Assumes all inputs are synchronous to clk.
module eee_lpi_ctrl
    import eee_lpi_pkg::*;
#(
    parameter int LS_W   = 11,
    parameter int TW_W   = 16,
    parameter int MS_DIV = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lpi_en,
    input  logic                 lpi_auto,
    input  logic                 phy_link_ok,
    input  logic                 irq_mask,
    input  logic [LS_W+TW_W-1:0] tmr_word,
    input  logic                 us_tick,
    input  logic                 tx_idle,
    input  logic                 tx_new_data,
    input  logic                 rx_lpi,
    input  logic                 stat_rd,
    output logic                 tx_lpi_req,
    output logic                 tx_block,
    output logic                 lpi_irq,
    output logic [EVT_N-1:0]     stat_flags
);
    logic [LS_W-1:0] ls_ms;
    logic [TW_W-1:0] tw_us;
    logic            link_ready;
    logic            ev_enter, ev_exit;

    // Timer word fields: wake time low, link-stable time high.
    assign tw_us = tmr_word[TW_W-1:0];
    assign ls_ms = tmr_word[LS_W+TW_W-1:TW_W];

    eee_lpi_link_timer #(.LS_W(LS_W), .MS_DIV(MS_DIV)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_ok    (phy_link_ok),
        .us_tick    (us_tick),
        .ls_ms      (ls_ms),
        .link_ready (link_ready)
    );

    eee_lpi_tx_fsm #(.TW_W(TW_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (lpi_en),
        .auto_entry  (lpi_auto),
        .tx_idle     (tx_idle),
        .tx_new_data (tx_new_data),
        .link_ready  (link_ready),
        .us_tick     (us_tick),
        .tw_us       (tw_us),
        .tx_lpi_req  (tx_lpi_req),
        .tx_block    (tx_block),
        .ev_enter    (ev_enter),
        .ev_exit     (ev_exit)
    );

    eee_lpi_evt_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_enter (ev_enter),
        .tx_exit  (ev_exit),
        .rx_lpi   (rx_lpi),
        .rd_clr   (stat_rd),
        .irq_mask (irq_mask),
        .flags    (stat_flags),
        .irq      (lpi_irq)
    );
endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
// Checker: port-level temporal rules of the LPI sequencer, bound to the top.
module eee_lpi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lpi_en,
    input logic       lpi_auto,
    input logic       phy_link_ok,
    input logic       irq_mask,
    input logic       tx_idle,
    input logic       tx_new_data,
    input logic       tx_lpi_req,
    input logic       tx_block,
    input logic       lpi_irq,
    input logic [3:0] stat_flags
);
    // R3/R5: entry only after a cycle with link good, enabled and no new data.
    a_r3_entry_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_lpi_req) |-> $past(phy_link_ok && lpi_en && !tx_new_data));

    // R5: automatic entry also needs transmit idle.
    a_r5_auto_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_lpi_req) && $past(lpi_auto)) |-> $past(tx_idle));

    // R6: an exit cause ends the request at the next edge.
    a_r6_exit_next: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lpi_req && (!lpi_en || tx_new_data)) |=> !tx_lpi_req);

    // R7: transmission is blocked throughout LPI.
    a_r7_block_in_lpi: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lpi_req |-> tx_block);

    // R8: entry and exit each leave their flag set.
    a_r8_enter_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_lpi_req) |-> stat_flags[0]);
    a_r8_exit_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_lpi_req) |-> stat_flags[1]);

    // R10: a masked interrupt stays low.
    a_r10_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !lpi_irq);
endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lpi_en      (lpi_en),
    .lpi_auto    (lpi_auto),
    .phy_link_ok (phy_link_ok),
    .irq_mask    (irq_mask),
    .tx_idle     (tx_idle),
    .tx_new_data (tx_new_data),
    .tx_lpi_req  (tx_lpi_req),
    .tx_block    (tx_block),
    .lpi_irq     (lpi_irq),
    .stat_flags  (stat_flags)
);

// File: tb/eee_lpi_ctrl_test.sv
// Bench: sweeps link-stable and wake times on a small prescaler and checks
// arithmetic expectations at the ports.
module eee_lpi_ctrl_test;
    localparam int CLK_PER = 10;
    localparam int LS_W    = 11;
    localparam int TW_W    = 16;
    localparam int MS_DIV  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lpi_en = 1'b0, lpi_auto = 1'b0, phy_link_ok = 1'b0, irq_mask = 1'b0;
    logic [LS_W+TW_W-1:0] tmr_word = '0;
    logic us_tick = 1'b1, tx_idle = 1'b0, tx_new_data = 1'b0, rx_lpi = 1'b0, stat_rd = 1'b0;
    logic tx_lpi_req, tx_block, lpi_irq;
    logic [3:0] stat_flags;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    eee_lpi_ctrl #(.LS_W(LS_W), .TW_W(TW_W), .MS_DIV(MS_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .lpi_en(lpi_en), .lpi_auto(lpi_auto),
        .phy_link_ok(phy_link_ok), .irq_mask(irq_mask), .tmr_word(tmr_word),
        .us_tick(us_tick), .tx_idle(tx_idle), .tx_new_data(tx_new_data),
        .rx_lpi(rx_lpi), .stat_rd(stat_rd), .tx_lpi_req(tx_lpi_req),
        .tx_block(tx_block), .lpi_irq(lpi_irq), .stat_flags(stat_flags)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic read_clear();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int ls_set [5] = '{0, 1, 2, 3, 5};
        int tw_set [5] = '{2, 0, 4, 1, 3};
        repeat (3) step();
        // R1: reset state
        chk(!tx_lpi_req && !tx_block, "R1 req/block", {tx_lpi_req, tx_block}, 0);
        chk(stat_flags == 4'b0 && !lpi_irq, "R1 flags/irq", {lpi_irq, stat_flags}, 0);
        rst_n = 1'b1; step();

        // R2/R3/R7/R8/R9: sweep link-stable and wake times
        foreach (ls_set[i]) begin
            tmr_word = {LS_W'(ls_set[i]), TW_W'(tw_set[i])};
            lpi_en = 1; lpi_auto = 1; tx_idle = 1; tx_new_data = 0; phy_link_ok = 0;
            step(); step();
            phy_link_ok = 1;
            n = 0;
            do begin step(); n++; end while (!tx_lpi_req && n < 200);
            chk(n == MS_DIV*ls_set[i] + 1, "R3 R2 entry delay", n, MS_DIV*ls_set[i] + 1);
            tx_new_data = 1; step();
            chk(!tx_lpi_req, "R6 exit on new data", tx_lpi_req, 0);
            n = 0;
            while (tx_block && n < 200) begin n++; step(); end
            chk(n == tw_set[i], "R7 R2 wake length", n, tw_set[i]);
            phy_link_ok = 0; step(); tx_new_data = 0;
            chk(stat_flags == 4'b0011, "R8 tx flags", stat_flags, 3);
            read_clear();
            chk(stat_flags == 4'b0000, "R9 read clears", stat_flags, 0);
        end

        // R4: link drop restarts the wait (ls=3 -> 13 edges)
        tmr_word = {LS_W'(3), TW_W'(0)};
        phy_link_ok = 1;
        n = 0;
        for (int k = 0; k < 8; k++) begin step(); if (tx_lpi_req) n++; end
        chk(n == 0, "R4 no early entry", n, 0);
        phy_link_ok = 0; step(); phy_link_ok = 1;
        n = 0;
        do begin step(); n++; end while (!tx_lpi_req && n < 200);
        chk(n == 13, "R4 restart delay", n, 13);
        // R6: exit on enable clear, tw=0 gives no block
        lpi_en = 0; step();
        chk(!tx_lpi_req && !tx_block, "R6 R7 exit on disable", {tx_lpi_req, tx_block}, 0);
        phy_link_ok = 0; read_clear();

        // R5: automatic entry needs idle; manual entry ignores idle
        tmr_word = '0; lpi_en = 1; lpi_auto = 1; tx_idle = 0; phy_link_ok = 1;
        n = 0;
        for (int k = 0; k < 10; k++) begin step(); if (tx_lpi_req) n++; end
        chk(n == 0, "R5 auto waits for idle", n, 0);
        lpi_auto = 0; step();
        chk(tx_lpi_req, "R5 manual ignores idle", tx_lpi_req, 1);
        lpi_en = 0; step();
        read_clear();
        lpi_auto = 1; tx_idle = 1;
        n = 0;
        for (int k = 0; k < 10; k++) begin step(); if (tx_lpi_req) n++; end
        chk(n == 0, "R5 disabled never enters", n, 0);
        lpi_en = 1; tx_new_data = 1;
        n = 0;
        for (int k = 0; k < 5; k++) begin step(); if (tx_lpi_req) n++; end
        chk(n == 0, "R5 new data blocks entry", n, 0);
        lpi_en = 0; tx_new_data = 0; phy_link_ok = 0; step();

        // R8/R10: receive flags and interrupt masking
        chk(!lpi_irq && stat_flags == 0, "R10 idle irq", lpi_irq, 0);
        rx_lpi = 1; step();
        chk(stat_flags == 4'b0100, "R8 rx entry flag", stat_flags, 4);
        chk(lpi_irq, "R10 irq raised", lpi_irq, 1);
        irq_mask = 1; step();
        chk(!lpi_irq, "R10 irq masked", lpi_irq, 0);
        irq_mask = 0;
        // R9: event during read survives
        rx_lpi = 0; stat_rd = 1; step(); stat_rd = 0;
        chk(stat_flags == 4'b1000, "R9 event wins over read", stat_flags, 8);
        read_clear();
        chk(stat_flags == 0 && !lpi_irq, "R9 R10 cleared", {lpi_irq, stat_flags}, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule